// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide register front end of an eight-line programmable interrupt controller. A host writes single bytes at two addresses. Offset 0 carries the command that starts initialization and the operational commands: end-of-interrupt and read control. Offset 1 carries the interrupt mask in normal operation. During initialization it carries the later configuration words. Which word a write at offset 1 stands for depends on an internal step counter. Steps are skipped according to the flags captured by the starting command.

The block holds the mask, the vector base, the cascade map (or the slave identity), the trigger mode, the cascade mode, the automatic end-of-interrupt flag and the read-source flag. It presents all of them as outputs to the priority core. It issues one-cycle end-of-interrupt strobes that carry either a line number or a "highest in-service line" flag. The request and in-service registers live in the priority core, and this block returns them on reads. Whether an instance is a master or a slave is a static parameter. Rotation, special mask and special nesting codes are accepted and do nothing.

Top module: `pic_prog_if`

## Requirements
- R1: After reset the mask, vector base and cascade map are 0x00, edge and cascade mode are 0, automatic end-of-interrupt is off, the read-source flag selects the request register (1), the init step is 0 and no end-of-interrupt strobe is active.
- R2: A write to offset 0 with bit 4 set starts initialization. It clears the mask, captures edge mode from bit 3, sets cascade mode when bit 1 is 0, records from bit 0 whether a mode word will follow, and moves the init step to 1.
- R3: A start command whose bit 0 is 0 clears automatic end-of-interrupt. A start command whose bit 0 is 1 leaves that flag unchanged.
- R4: At step 1, a write to offset 1 sets the vector base to the byte with its low three bits forced to 0. In cascade mode the step becomes 2. Otherwise the cascade map is cleared and the step becomes 0.
- R5: At step 2, a write to offset 1 in a master instance stores the whole byte as the cascade map. The step then becomes 3 if a mode word is expected, and 0 if not.
- R6: At step 3, bit 1 of a write to offset 1 becomes the automatic end-of-interrupt flag, and the step becomes 0.
- R7: At step 0, a write to offset 1 loads the mask with the byte. The mask changes on no other event except the start command.
- R8: A write to offset 0 whose bits 4:3 are 00 and bits 7:5 are 001 raises the strobe output for exactly the cycle after the write, with the highest-line flag set to 1.
- R9: A write to offset 0 whose bits 4:3 are 00 and bits 7:5 are 011 raises the strobe output in the cycle after the write, with the highest-line flag at 0 and the line output equal to bits 2:0.
- R10: Any other code in bits 7:5 with bits 4:3 at 00 raises no strobe and leaves the mask, step and read source unchanged.
- R11: A write to offset 0 whose bits 4:3 are 01 and whose bit 1 is 1 sets the read source from bit 0 (1 selects the request register, 0 selects the in-service register). When bit 1 is 0 the read source is unchanged.
- R12: The read data is combinational. At offset 0 it is the request or the in-service byte, as the read source selects. At offset 1 it is the mask.
- R13: A slave instance stores only the low three bits of the step-2 byte, as its identity, with the upper bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| addr | input | 1 | Register offset (0 or 1) |
| wdata | input | 8 | Write byte |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| rdata | output | 8 | Read byte for the current offset |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| casc_map_o | output | 8 | Slave map (master) or identity (slave) |
| edge_mode_o | output | 1 | 1 = edge-triggered inputs |
| cascade_mode_o | output | 1 | 1 = cascaded configuration |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enable |
| rd_req_sel_o | output | 1 | 1 = offset 0 reads the request register |
| init_step_o | output | 2 | Initialization step, 0 when idle |
| eoi_stb_o | output | 1 | End-of-interrupt strobe |
| eoi_any_o | output | 1 | 1 = clear the highest in-service line |
| eoi_line_o | output | 3 | Line to clear for a specific end-of-interrupt |

## Verification
The assertions assume that `wr_en` is a one-cycle pulse sampled at a rising edge, and that `addr` and `wdata` are stable at that edge. They assume nothing about the order of writes. A start command may arrive at any step, and an operational command may come in the middle of initialization. The bench drives every input on the falling edge and holds each write for one full cycle. It samples registered outputs at the next falling edge, so each check sees the effect of exactly one write. Request and in-service bytes change only while no write is pending.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;

   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_BASE = 2'd1,
      STEP_LINK = 2'd2,
      STEP_MODE = 2'd3
   } step_e;

   typedef struct packed {
      logic       init1;     // start-of-initialization command
      logic       op_eoi;    // operation command class (bits 4:3 == 00)
      logic       rdctl;     // read-control class (bits 4:3 == 01)
      logic       port1_wr;  // any write at offset 1
      logic [2:0] code;      // operation sub-code
      logic [2:0] line;      // line field
      logic       sel_upd;   // read-control update enable
      logic       sel_req;   // read-control source choice
   } cmd_t;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
   import pic_prog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output cmd_t              cmd
);
   if (DATA_W != 8) begin : g_chk_w
      $error("pic_cmd_decode: DATA_W must be 8");
   end

   logic port0_wr;
   assign port0_wr = wr_en && !addr;

   always_comb begin
      cmd          = '0;
      cmd.init1    = port0_wr && wdata[4];
      cmd.op_eoi   = port0_wr && (wdata[4:3] == 2'b00);
      cmd.rdctl    = port0_wr && (wdata[4:3] == 2'b01);
      cmd.port1_wr = wr_en && addr;
      cmd.code     = wdata[7:5];
      cmd.line     = wdata[2:0];
      cmd.sel_upd  = wdata[1];
      cmd.sel_req  = wdata[0];
   end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_prog_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init1,
   input  logic              port1_wr,
   input  logic [DATA_W-1:0] wdata,
   output step_e             step,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] casc_map,
   output logic              edge_mode,
   output logic              cascade_mode,
   output logic              auto_eoi
);
   localparam int LINE_W = $clog2(NUM_LINES);

   if (NUM_LINES != DATA_W) begin : g_chk_lines
      $error("pic_init_seq: NUM_LINES must equal DATA_W");
   end

   logic              want_mode;
   logic [DATA_W-1:0] map_next;
   logic [DATA_W-1:0] base_next;

   assign base_next = {wdata[DATA_W-1:LINE_W], {LINE_W{1'b0}}};

   if (IS_MASTER) begin : g_master
      assign map_next = wdata;
   end else begin : g_slave
      assign map_next = {{(DATA_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step         <= STEP_IDLE;
         mask         <= '0;
         vec_base     <= '0;
         casc_map     <= '0;
         edge_mode    <= 1'b0;
         cascade_mode <= 1'b0;
         want_mode    <= 1'b0;
         auto_eoi     <= 1'b0;
      end else if (init1) begin
         mask         <= '0;
         edge_mode    <= wdata[3];
         cascade_mode <= ~wdata[1];
         want_mode    <= wdata[0];
         if (!wdata[0]) auto_eoi <= 1'b0;
         step         <= STEP_BASE;
      end else if (port1_wr) begin
         unique case (step)
            STEP_IDLE: mask <= wdata;
            STEP_BASE: begin
               vec_base <= base_next;
               if (cascade_mode) begin
                  step <= STEP_LINK;
               end else begin
                  casc_map <= '0;
                  step     <= STEP_IDLE;
               end
            end
            STEP_LINK: begin
               casc_map <= map_next;
               step     <= want_mode ? STEP_MODE : STEP_IDLE;
            end
            STEP_MODE: begin
               auto_eoi <= wdata[1];
               step     <= STEP_IDLE;
            end
            default: step <= STEP_IDLE;
         endcase
      end
   end

   a_r2_start_step: assert property (@(posedge clk) disable iff (!rst_n)
      init1 |=> (step == STEP_BASE) && (mask == '0));

   a_r4_single_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STEP_BASE && port1_wr && !init1 && !cascade_mode)
      |=> (step == STEP_IDLE) && (casc_map == '0));

   a_r6_mode_done: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STEP_MODE && port1_wr && !init1) |=> (step == STEP_IDLE));

   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!init1 && !(port1_wr && step == STEP_IDLE)) |=> $stable(mask));

   a_r4_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_base[LINE_W-1:0] == '0));
endmodule

// File: rtl/pic_op_ctl.sv
module pic_op_ctl #(
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         op_eoi,
   input  logic                         rdctl,
   input  logic [2:0]                   code,
   input  logic [2:0]                   line,
   input  logic                         sel_upd,
   input  logic                         sel_req,
   input  logic                         addr,
   input  logic [DATA_W-1:0]            irr_in,
   input  logic [DATA_W-1:0]            isr_in,
   input  logic [DATA_W-1:0]            mask,
   output logic [DATA_W-1:0]            rdata,
   output logic                         rd_req_sel,
   output logic                         eoi_stb,
   output logic                         eoi_any,
   output logic [$clog2(NUM_LINES)-1:0] eoi_line
);
   localparam int         LINE_W    = $clog2(NUM_LINES);
   localparam logic [2:0] CODE_ANY  = 3'b001;
   localparam logic [2:0] CODE_LINE = 3'b011;

   if (LINE_W != 3) begin : g_chk_line_w
      $error("pic_op_ctl: line field is three bits wide");
   end

   logic hit_any, hit_line;
   assign hit_any  = op_eoi && (code == CODE_ANY);
   assign hit_line = op_eoi && (code == CODE_LINE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoi_stb    <= 1'b0;
         eoi_any    <= 1'b0;
         eoi_line   <= '0;
         rd_req_sel <= 1'b1;
      end else begin
         eoi_stb <= hit_any || hit_line;
         if (hit_any || hit_line) begin
            eoi_any  <= hit_any;
            eoi_line <= line;
         end
         if (rdctl && sel_upd) rd_req_sel <= sel_req;
      end
   end

   always_comb begin
      if (addr)            rdata = mask;
      else if (rd_req_sel) rdata = irr_in;
      else                 rdata = isr_in;
   end

   a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_stb |-> $past(op_eoi) && ($past(code) == CODE_ANY || $past(code) == CODE_LINE));

   a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !op_eoi |=> !eoi_stb);

   a_r9_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb && !eoi_any) |-> (eoi_line == $past(line)));

   a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(rdctl && sel_upd) |=> $stable(rd_req_sel));
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
   import pic_prog_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        addr,
   input  logic [7:0]  wdata,
   input  logic [7:0]  irr_in,
   input  logic [7:0]  isr_in,
   output logic [7:0]  rdata,
   output logic [7:0]  mask_o,
   output logic [7:0]  vec_base_o,
   output logic [7:0]  casc_map_o,
   output logic        edge_mode_o,
   output logic        cascade_mode_o,
   output logic        auto_eoi_o,
   output logic        rd_req_sel_o,
   output logic [1:0]  init_step_o,
   output logic        eoi_stb_o,
   output logic        eoi_any_o,
   output logic [2:0]  eoi_line_o
);
   if (DATA_W != 8 || NUM_LINES != 8) begin : g_chk_top
      $error("pic_prog_if: ports are sized for eight lines of one byte");
   end

   cmd_t  cmd;
   step_e step;

   pic_cmd_decode #(.DATA_W(DATA_W)) u_dec (
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .cmd   (cmd)
   );

   pic_init_seq #(
      .DATA_W    (DATA_W),
      .NUM_LINES (NUM_LINES),
      .IS_MASTER (IS_MASTER)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .init1        (cmd.init1),
      .port1_wr     (cmd.port1_wr),
      .wdata        (wdata),
      .step         (step),
      .mask         (mask_o),
      .vec_base     (vec_base_o),
      .casc_map     (casc_map_o),
      .edge_mode    (edge_mode_o),
      .cascade_mode (cascade_mode_o),
      .auto_eoi     (auto_eoi_o)
   );

   pic_op_ctl #(
      .DATA_W    (DATA_W),
      .NUM_LINES (NUM_LINES)
   ) u_op (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_eoi     (cmd.op_eoi),
      .rdctl      (cmd.rdctl),
      .code       (cmd.code),
      .line       (cmd.line),
      .sel_upd    (cmd.sel_upd),
      .sel_req    (cmd.sel_req),
      .addr       (addr),
      .irr_in     (irr_in),
      .isr_in     (isr_in),
      .mask       (mask_o),
      .rdata      (rdata),
      .rd_req_sel (rd_req_sel_o),
      .eoi_stb    (eoi_stb_o),
      .eoi_any    (eoi_any_o),
      .eoi_line   (eoi_line_o)
   );

   assign init_step_o = step;

   a_r5_link_next: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STEP_LINK && wr_en && addr) |=> (init_step_o == 2'd0 || init_step_o == 2'd3));

   a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb_o && !$past(wr_en)) |-> 1'b0);
endmodule

// File: tb/tb_pic_prog_if.sv
module tb_pic_prog_if;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic wr_en, addr;
   logic [7:0] wdata, irr_in, isr_in;
   logic [7:0] rdata, mask_o, vec_base_o, casc_map_o;
   logic edge_mode_o, cascade_mode_o, auto_eoi_o, rd_req_sel_o;
   logic [1:0] init_step_o;
   logic eoi_stb_o, eoi_any_o;
   logic [2:0] eoi_line_o;

   logic [7:0] s_rdata, s_mask, s_vec, s_map;
   logic s_edge, s_casc, s_auto, s_sel, s_stb, s_any;
   logic [1:0] s_step;
   logic [2:0] s_line;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pic_prog_if #(.IS_MASTER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .irr_in(irr_in), .isr_in(isr_in), .rdata(rdata), .mask_o(mask_o),
      .vec_base_o(vec_base_o), .casc_map_o(casc_map_o), .edge_mode_o(edge_mode_o),
      .cascade_mode_o(cascade_mode_o), .auto_eoi_o(auto_eoi_o),
      .rd_req_sel_o(rd_req_sel_o), .init_step_o(init_step_o), .eoi_stb_o(eoi_stb_o),
      .eoi_any_o(eoi_any_o), .eoi_line_o(eoi_line_o));

   pic_prog_if #(.IS_MASTER(1'b0)) dut_slave (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .irr_in(irr_in), .isr_in(isr_in), .rdata(s_rdata), .mask_o(s_mask),
      .vec_base_o(s_vec), .casc_map_o(s_map), .edge_mode_o(s_edge),
      .cascade_mode_o(s_casc), .auto_eoi_o(s_auto), .rd_req_sel_o(s_sel),
      .init_step_o(s_step), .eoi_stb_o(s_stb), .eoi_any_o(s_any), .eoi_line_o(s_line));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one write; returns at the falling edge after the capturing rising edge
   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = 8'h00;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic t_reset();
      chk("R1 mask", mask_o, 8'h00);
      chk("R1 vec", vec_base_o, 8'h00);
      chk("R1 map", casc_map_o, 8'h00);
      chk("R1 flags", {edge_mode_o, cascade_mode_o, auto_eoi_o, rd_req_sel_o}, 8'h01);
      chk("R1 step", {6'd0, init_step_o}, 8'h00);
      chk("R1 strobe", {7'd0, eoi_stb_o}, 8'h00);
   endtask

   task automatic t_mask_load();
      logic [7:0] d;
      wr(1'b1, 8'hFF);
      chk("R7 mask load", mask_o, 8'hFF);
      rd(1'b1, d);
      chk("R12 read mask", d, 8'hFF);
   endtask

   task automatic t_full_init();
      wr(1'b0, 8'h19);
      chk("R2 mask cleared", mask_o, 8'h00);
      chk("R2 edge/cascade", {6'd0, edge_mode_o, cascade_mode_o}, 8'h03);
      chk("R2 step", {6'd0, init_step_o}, 8'h01);
      wr(1'b1, 8'h2D);
      chk("R4 vec base", vec_base_o, 8'h28);
      chk("R4 step to 2", {6'd0, init_step_o}, 8'h02);
      wr(1'b1, 8'hA4);
      chk("R5 master map", casc_map_o, 8'hA4);
      chk("R5 step to 3", {6'd0, init_step_o}, 8'h03);
      wr(1'b1, 8'h03);
      chk("R6 auto eoi", {7'd0, auto_eoi_o}, 8'h01);
      chk("R6 step to 0", {6'd0, init_step_o}, 8'h00);
      wr(1'b1, 8'h3C);
      chk("R7 mask after init", mask_o, 8'h3C);
   endtask

   task automatic t_single_clear();
      wr(1'b0, 8'h12);
      chk("R3 auto cleared", {7'd0, auto_eoi_o}, 8'h00);
      chk("R2 single level", {6'd0, edge_mode_o, cascade_mode_o}, 8'h00);
      wr(1'b1, 8'h47);
      chk("R4 single base", vec_base_o, 8'h40);
      chk("R4 single step 0", {6'd0, init_step_o}, 8'h00);
      chk("R4 single map cleared", casc_map_o, 8'h00);
   endtask

   task automatic t_keep_auto();
      wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
      chk("R6 auto set", {7'd0, auto_eoi_o}, 8'h01);
      wr(1'b0, 8'h19);
      chk("R3 auto kept", {7'd0, auto_eoi_o}, 8'h01);
      wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
      chk("R6 auto off", {7'd0, auto_eoi_o}, 8'h00);
   endtask

   task automatic t_cascade_no_mode();
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h08);
      chk("R4 cascade step 2", {6'd0, init_step_o}, 8'h02);
      wr(1'b1, 8'h55);
      chk("R5 map stored", casc_map_o, 8'h55);
      chk("R5 skip mode word", {6'd0, init_step_o}, 8'h00);
   endtask

   task automatic t_eoi();
      wr(1'b1, 8'h5A);
      wr(1'b0, 8'h20);
      chk("R8 nonspecific strobe", {6'd0, eoi_stb_o, eoi_any_o}, 8'h03);
      @(negedge clk);
      chk("R8 one cycle", {7'd0, eoi_stb_o}, 8'h00);
      wr(1'b0, 8'h63);
      chk("R9 specific strobe", {6'd0, eoi_stb_o, eoi_any_o}, 8'h02);
      chk("R9 line 3", {5'd0, eoi_line_o}, 8'h03);
      wr(1'b0, 8'h67);
      chk("R9 line 7", {5'd0, eoi_line_o}, 8'h07);
      foreach (codes[i]) begin
         wr(1'b0, codes[i]);
         chk($sformatf("R10 code %h strobe", codes[i]), {7'd0, eoi_stb_o}, 8'h00);
      end
      chk("R10 mask unchanged", mask_o, 8'h5A);
      chk("R10 step unchanged", {6'd0, init_step_o}, 8'h00);
      chk("R10 read sel unchanged", {7'd0, rd_req_sel_o}, 8'h01);
   endtask

   logic [7:0] codes [6] = '{8'h40, 8'hA0, 8'hC5, 8'hE2, 8'h00, 8'h80};

   task automatic t_read_sel();
      logic [7:0] d;
      irr_in = 8'h81; isr_in = 8'h42;
      rd(1'b0, d);
      chk("R12 read request", d, 8'h81);
      wr(1'b0, 8'h0A);
      rd(1'b0, d);
      chk("R11 select in-service", d, 8'h42);
      wr(1'b0, 8'h09);
      rd(1'b0, d);
      chk("R11 no update when bit1 clear", d, 8'h42);
      wr(1'b0, 8'h0B);
      rd(1'b0, d);
      chk("R11 select request", d, 8'h81);
   endtask

   task automatic t_slave();
      wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'hFE); wr(1'b1, 8'h00);
      chk("R13 slave identity", s_map, 8'h06);
      chk("R5 master full byte", casc_map_o, 8'hFE);
      chk("R6 slave step 0", {6'd0, s_step}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
      irr_in = 8'h00; isr_in = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_load();
      t_full_init();
      t_single_clear();
      t_keep_auto();
      t_cascade_no_mode();
      t_eoi();
      t_read_sel();
      t_slave();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule